// File: doc/BRIEF.md
# Serial Signaling Stream Output Multiplexer

This block builds the 2.048 Mbit/s serial stream that carries one framer's received signaling towards the system side. A frame holds 32 channels of eight bits each. The block runs from a 4.096 MHz bit clock, so each bit lasts two clock cycles. An active-low frame pulse starts channel 0. Bits go out most significant bit first. Each bit comes with its own output-enable, which models a tri-state pin: whatever is not driven floats.

Four modes decide what each channel carries:
- **Nibble modes.** Per-channel ABCD signaling nibbles go out in the low half of a channel. The T1 variant uses the first 24 channels; the E1 variant uses all 32.
- **Common-channel modes.** Whole received timeslot bytes are steered onto chosen output channels, so an external multi-channel HDLC receiver can pick them up.

Mode, enable and timeslot map are captured at frame start only, so a frame never shows a half-applied change. Each channel's content is captured when that channel begins.

Top module: `sig_stream_mux`

## Requirements
- R1: A low `frame_n` seen at a clock edge restarts the frame. After that edge, bit 7 of channel 0 is presented. Channel c, bit p (7..0) is presented during the two cycles that follow edge 16c+2(7-p) counted from that edge. Without a new pulse the 512-cycle frame repeats.
- R2: After reset, and in every frame whose captured enable is 0, `oe_o` stays 0 in every bit.
- R3: With mode 2'b00 (T1 signaling), channels 0..23 drive bits 3..0 with `nib_i[4c+3:4c]`, and channels 24..31 float entirely.
- R4: In both nibble modes (2'b00, 2'b01), bits 7..4 of every channel float.
- R5: With mode 2'b01 (E1 signaling), every one of the 32 channels drives bits 3..0 with its own nibble.
- R6: With mode 2'b10 (T1 common-channel), an enabled timeslot t<24 whose destination d<24 appears as the full byte `ts_i[8t+7:8t]` in channel d. Timeslots 24..31 and destinations 24..31 are ignored.
- R7: With mode 2'b11 (E1 common-channel), only timeslots 15, 16 and 31 can be mapped, and each can go to any of the 32 channels.
- R8: In the common-channel modes, a channel that receives no mapped timeslot floats in all eight bits.
- R9: When several eligible enabled timeslots name the same channel, the lowest-numbered one is output.
- R10: Changes on `mode_i`, `enable_i`, `map_en_i` and `map_dst_i` made during a frame have no effect before the next frame start.
- R11: Timeslot t uses enable bit `map_en_i[t]` and destination field `map_dst_i[5t+4:5t]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame start pulse |
| enable_i | input | 1 | Stream enable; when 0 the whole stream floats |
| mode_i | input | 2 | 00 T1 signaling, 01 E1 signaling, 10 T1 common-channel, 11 E1 common-channel |
| map_en_i | input | 32 | Per-timeslot map enable |
| map_dst_i | input | 160 | Per-timeslot destination channel, 5 bits each |
| nib_i | input | 128 | Per-channel ABCD nibbles, 4 bits each |
| ts_i | input | 256 | Received timeslot bytes, 8 bits each |
| sdo_o | output | 1 | Serial data bit |
| oe_o | output | 1 | Drive enable for the current bit |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a frame while channels are still being emitted. The RTL must keep using the settings captured at frame start, and this cannot be seen unless the new settings would visibly change later channels. To get there, the random frames rewrite mode, enable and map at a fixed bit position inside the frame, while the expected values stay tied to a snapshot taken at the frame pulse. Collisions between timeslots are made likely by drawing destinations from a narrow range. Directed frames cover the cases that must be ignored: ineligible timeslots and destinations beyond channel 23 in T1 mode.

// File: rtl/sig_mux_pkg.sv
package sig_mux_pkg;

    typedef enum logic [1:0] {
        MODE_T1_NIB = 2'd0,
        MODE_E1_NIB = 2'd1,
        MODE_T1_CC  = 2'd2,
        MODE_E1_CC  = 2'd3
    } sig_mode_e;

endpackage

// File: rtl/sig_bit_counter.sv
module sig_bit_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!frame_n) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;

endmodule

// File: rtl/sig_chan_select.sv
module sig_chan_select
    import sig_mux_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned T1_CH  = 24,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned NIB_W  = 4,
    parameter int unsigned E1_TS_A = 15,
    parameter int unsigned E1_TS_B = 16,
    parameter int unsigned E1_TS_C = 31,
    localparam int unsigned TS_W  = $clog2(NUM_CH)
) (
    input  logic [TS_W-1:0]        ch_i,
    input  sig_mode_e              mode_i,
    input  logic                   en_i,
    input  logic [NUM_CH-1:0]      map_en_i,
    input  logic [NUM_CH*TS_W-1:0] map_dst_i,
    input  logic [NUM_CH*NIB_W-1:0] nib_i,
    input  logic [NUM_CH*CH_W-1:0] ts_i,
    output logic [CH_W-1:0]        data_o,
    output logic [CH_W-1:0]        mask_o
);

    localparam logic [CH_W-1:0] LO_MASK = CH_W'((1 << NIB_W) - 1);

    logic            hit;
    logic [TS_W-1:0] sel;
    logic            t1_ch_ok;

    assign t1_ch_ok = (int'(ch_i) < int'(T1_CH));

    function automatic logic eligible(input sig_mode_e m, input int t, input logic ch_ok);
        case (m)
            MODE_T1_CC: eligible = ch_ok && (t < int'(T1_CH));
            MODE_E1_CC: eligible = (t == int'(E1_TS_A)) || (t == int'(E1_TS_B)) ||
                                   (t == int'(E1_TS_C));
            default:    eligible = 1'b0;
        endcase
    endfunction

    // Scan downwards so the lowest matching timeslot is the last written.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int t = NUM_CH - 1; t >= 0; t--) begin
            if (eligible(mode_i, t, t1_ch_ok) && map_en_i[t] &&
                (map_dst_i[t*TS_W +: TS_W] == ch_i)) begin
                hit = 1'b1;
                sel = TS_W'(t);
            end
        end
    end

    always_comb begin
        data_o = '0;
        mask_o = '0;
        if (en_i) begin
            case (mode_i)
                MODE_T1_NIB: begin
                    if (t1_ch_ok) begin
                        data_o = CH_W'(nib_i[ch_i*NIB_W +: NIB_W]);
                        mask_o = LO_MASK;
                    end
                end
                MODE_E1_NIB: begin
                    data_o = CH_W'(nib_i[ch_i*NIB_W +: NIB_W]);
                    mask_o = LO_MASK;
                end
                default: begin
                    if (hit) begin
                        data_o = ts_i[sel*CH_W +: CH_W];
                        mask_o = '1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sig_stream_mux.sv
module sig_stream_mux
    import sig_mux_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned T1_CH  = 24,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned NIB_W  = 4,
    localparam int unsigned TS_W  = $clog2(NUM_CH),
    localparam int unsigned BIT_W = $clog2(CH_W),
    localparam int unsigned CNT_W = TS_W + BIT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_n,
    input  logic                     enable_i,
    input  logic [1:0]               mode_i,
    input  logic [NUM_CH-1:0]        map_en_i,
    input  logic [NUM_CH*TS_W-1:0]   map_dst_i,
    input  logic [NUM_CH*NIB_W-1:0]  nib_i,
    input  logic [NUM_CH*CH_W-1:0]   ts_i,
    output logic                     sdo_o,
    output logic                     oe_o
);

    typedef struct packed {
        sig_mode_e                mode;
        logic                     en;
        logic [NUM_CH-1:0]        men;
        logic [NUM_CH*TS_W-1:0]   dst;
    } cfg_t;

    typedef struct packed {
        cfg_t            cfg;
        logic [CH_W-1:0] shift;
        logic [CH_W-1:0] mask;
    } state_t;

    localparam int unsigned CFG_W = $bits(cfg_t);

    state_t st_d, st_q;
    cfg_t   cfg_n;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [TS_W-1:0]  ch_nx;
    logic             frame_start;
    logic             chan_start;
    logic             bit_start;
    logic [CH_W-1:0]  ld_data;
    logic [CH_W-1:0]  ld_mask;

    // Exposed for the bound checker.
    logic [1:0]       mode_act;
    logic             en_act;
    logic [CFG_W-1:0] cfg_flat;

    sig_bit_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .cnt_o     (cnt_q),
        .cnt_next_o(cnt_nx)
    );

    assign ch_nx       = cnt_nx[CNT_W-1 -: TS_W];
    assign frame_start = (cnt_nx == '0);
    assign chan_start  = (cnt_nx[BIT_W:0] == '0);
    assign bit_start   = ~cnt_nx[0];

    always_comb begin
        cfg_n = st_q.cfg;
        if (frame_start) begin
            cfg_n.mode = sig_mode_e'(mode_i);
            cfg_n.en   = enable_i;
            cfg_n.men  = map_en_i;
            cfg_n.dst  = map_dst_i;
        end
    end

    sig_chan_select #(
        .NUM_CH(NUM_CH),
        .T1_CH (T1_CH),
        .CH_W  (CH_W),
        .NIB_W (NIB_W)
    ) sel_i (
        .ch_i     (ch_nx),
        .mode_i   (cfg_n.mode),
        .en_i     (cfg_n.en),
        .map_en_i (cfg_n.men),
        .map_dst_i(cfg_n.dst),
        .nib_i    (nib_i),
        .ts_i     (ts_i),
        .data_o   (ld_data),
        .mask_o   (ld_mask)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_n;
        if (chan_start) begin
            st_d.shift = ld_data;
            st_d.mask  = ld_mask;
        end else if (bit_start) begin
            st_d.shift = {st_q.shift[CH_W-2:0], 1'b0};
            st_d.mask  = {st_q.mask[CH_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o    = st_q.shift[CH_W-1] & st_q.mask[CH_W-1];
    assign oe_o     = st_q.mask[CH_W-1];
    assign mode_act = st_q.cfg.mode;
    assign en_act   = st_q.cfg.en;
    assign cfg_flat = st_q.cfg;

endmodule

// File: rtl/sig_stream_mux_chk.sv
module sig_stream_mux_chk #(
    parameter int unsigned CNT_W = 9,
    parameter int unsigned CFG_W = 8,
    parameter int unsigned T1_CH = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       mode_act,
    input logic             en_act,
    input logic [CFG_W-1:0] cfg_flat,
    input logic             sdo_o,
    input logic             oe_o
);

    logic       nib_mode;
    logic       t1_mode;
    logic [2:0] bit_pos;
    logic [4:0] ch_pos;

    assign nib_mode = (mode_act == 2'd0) || (mode_act == 2'd1);
    assign t1_mode  = (mode_act == 2'd0) || (mode_act == 2'd2);
    assign bit_pos  = cnt_q[3:1];
    assign ch_pos   = cnt_q[CNT_W-1 -: 5];

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (cnt_q == '0)); // R1

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[0] |-> ($stable(sdo_o) && $stable(oe_o))); // R1

    AST_OFF_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |-> !oe_o); // R2

    AST_T1_TAIL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_mode && (int'(ch_pos) >= int'(T1_CH))) |-> !oe_o); // R3

    AST_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_mode && (bit_pos < 3'd4)) |-> !oe_o); // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(cfg_flat)); // R10

endmodule

bind sig_stream_mux sig_stream_mux_chk #(
    .CNT_W(CNT_W),
    .CFG_W(CFG_W),
    .T1_CH(T1_CH)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .cnt_q   (cnt_q),
    .mode_act(mode_act),
    .en_act  (en_act),
    .cfg_flat(cfg_flat),
    .sdo_o   (sdo_o),
    .oe_o    (oe_o)
);

// File: tb/sig_stream_mux_tb.sv
module sig_stream_mux_tb_top;

    localparam int NCH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1;
    logic enable_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [NCH-1:0] map_en_i;
    logic [NCH*5-1:0] map_dst_i;
    logic [NCH*4-1:0] nib_i;
    logic [NCH*8-1:0] ts_i;
    logic sdo_o, oe_o;

    logic [3:0] nib [NCH];
    logic [7:0] tsb [NCH];
    logic       men [NCH];
    logic [4:0] dst [NCH];

    logic [1:0] a_mode;
    logic       a_en;
    logic       a_men [NCH];
    logic [4:0] a_dst [NCH];

    logic [7:0] obs_d  [NCH];
    logic [7:0] obs_oe [NCH];

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            nib_i[i*4 +: 4]     = nib[i];
            ts_i[i*8 +: 8]      = tsb[i];
            map_en_i[i]         = men[i];
            map_dst_i[i*5 +: 5] = dst[i];
        end
    end

    sig_stream_mux dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .enable_i(enable_i),
        .mode_i(mode_i), .map_en_i(map_en_i), .map_dst_i(map_dst_i),
        .nib_i(nib_i), .ts_i(ts_i), .sdo_o(sdo_o), .oe_o(oe_o)
    );

    function automatic bit ts_ok(input logic [1:0] m, input int t, input int ch);
        if (m == 2'd2) return (t < 24) && (ch < 24);
        if (m == 2'd3) return (t == 15) || (t == 16) || (t == 31);
        return 1'b0;
    endfunction

    task automatic expect_ch(input int ch, output logic [7:0] d, output logic [7:0] m,
                             output string tag);
        int hits = 0;
        int win = -1;
        d = 8'h00; m = 8'h00; tag = "R1,R11";
        if (!a_en) begin
            tag = {tag, ",R2"};
            return;
        end
        case (a_mode)
            2'd0: begin
                tag = {tag, ",R3,R4"};
                if (ch < 24) begin d = {4'h0, nib[ch]}; m = 8'h0F; end
            end
            2'd1: begin
                tag = {tag, ",R5,R4"};
                d = {4'h0, nib[ch]}; m = 8'h0F;
            end
            default: begin
                tag = {tag, (a_mode == 2'd2) ? ",R6" : ",R7"};
                for (int t = 0; t < NCH; t++) begin
                    if (ts_ok(a_mode, t, ch) && a_men[t] && (int'(a_dst[t]) == ch)) begin
                        hits++;
                        if (win < 0) win = t;
                    end
                end
                if (hits == 0) tag = {tag, ",R8"};
                else begin
                    d = tsb[win]; m = 8'hFF;
                    if (hits > 1) tag = {tag, ",R9"};
                end
            end
        endcase
    endtask

    task automatic rand_cfg();
        mode_i   = 2'($urandom % 4);
        enable_i = ($urandom % 8) != 0;
        for (int t = 0; t < NCH; t++) begin
            men[t] = ($urandom % 2) == 1;
            dst[t] = ($urandom % 2) == 1 ? 5'($urandom % 4) : 5'($urandom % 32);
        end
    endtask

    task automatic rand_data();
        for (int i = 0; i < NCH; i++) begin
            nib[i] = 4'($urandom);
            tsb[i] = 8'($urandom);
        end
    endtask

    task automatic clear_map();
        for (int t = 0; t < NCH; t++) begin men[t] = 1'b0; dst[t] = 5'd0; end
    endtask

    // Called at a negedge. Issues a frame pulse, samples all 256 bits,
    // optionally rewrites the configuration mid-frame, then checks.
    task automatic run_frame(input bit scramble);
        logic [7:0] ed, em;
        string tag;
        a_mode = mode_i; a_en = enable_i;
        for (int t = 0; t < NCH; t++) begin a_men[t] = men[t]; a_dst[t] = dst[t]; end
        frame_n = 1'b0;
        @(negedge clk);
        frame_n = 1'b1;
        for (int pos = 0; pos < 256; pos++) begin
            obs_d[pos/8][7 - pos%8]  = sdo_o;
            obs_oe[pos/8][7 - pos%8] = oe_o;
            if (scramble && pos == 100) rand_cfg();
            @(negedge clk);
            if (pos != 255) @(negedge clk);
        end
        for (int ch = 0; ch < NCH; ch++) begin
            expect_ch(ch, ed, em, tag);
            if (scramble) tag = {tag, ",R10"};
            total++;
            if ((obs_oe[ch] !== em) || ((obs_d[ch] & em) !== (ed & em))) begin
                bad++;
                $display("FAIL %s ch=%0d actual d=%h oe=%h expected d=%h oe=%h",
                         tag, ch, obs_d[ch], obs_oe[ch], ed, em);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit rst_bad;
        void'($urandom(32'd20240607));
        rand_data();
        clear_map();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state floats
        rst_bad = 1'b0;
        repeat (20) begin @(negedge clk); if (oe_o !== 1'b0) rst_bad = 1'b1; end
        total++;
        if (rst_bad) begin
            bad++;
            $display("FAIL R2 reset state actual oe=1 expected oe=0");
        end

        // E1 nibbles with a recognisable pattern
        for (int i = 0; i < NCH; i++) nib[i] = 4'(i ^ 5);
        mode_i = 2'd1; enable_i = 1'b1;
        run_frame(1'b0);
        // T1 nibbles
        mode_i = 2'd0;
        run_frame(1'b0);
        // disabled
        enable_i = 1'b0; mode_i = 2'd3;
        run_frame(1'b0);
        // T1 common-channel: collision, ineligible slot, out-of-range destination
        enable_i = 1'b1; mode_i = 2'd2; clear_map();
        men[3] = 1; dst[3] = 5'd23;
        men[20] = 1; dst[20] = 5'd23;
        men[25] = 1; dst[25] = 5'd2;
        men[5] = 1; dst[5] = 5'd30;
        men[0] = 1; dst[0] = 5'd0;
        run_frame(1'b0);
        // E1 common-channel: collision and ineligible slot
        mode_i = 2'd3; clear_map();
        men[16] = 1; dst[16] = 5'd7;
        men[31] = 1; dst[31] = 5'd7;
        men[15] = 1; dst[15] = 5'd31;
        men[10] = 1; dst[10] = 5'd1;
        run_frame(1'b0);
        // R10 directed: enable dropped mid-frame must not cut the stream
        mode_i = 2'd1; enable_i = 1'b1;
        a_mode = 2'd1;
        fork
            run_frame(1'b0);
            begin
                repeat (300) @(negedge clk);
                enable_i = 1'b0; mode_i = 2'd2;
            end
        join
        // constrained random frames with mid-frame reconfiguration
        for (int f = 0; f < 30; f++) begin
            rand_data();
            rand_cfg();
            run_frame(1'b1);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule